// File: doc/BRIEF.md
# Red-Before-Green Light Detector

This block watches a traffic light through two indication inputs, one for red and one for green, and samples them on every clock edge. It raises its detect output only when a red light has been seen at some earlier clock edge and the light is green in the present cycle. The output depends on that past red as well as on the current colour. A green light on its own, with no red seen before it, never raises the output.

The history is held in a single registered bit. It starts at 0 after reset and is set by the first red light it samples. Once set, it stays set until the next reset. The detect output is formed by combinational logic from that bit and the current green input, so it is a Mealy output and follows the green input within the same cycle. The history bit is also driven out on its own port, so the surrounding logic can see whether a red light has been seen.

Top module: `seen_red_go_detector`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` at 1 clears `armed` to 0 for the following cycle, whatever `lamp_red` and `lamp_green` are at that edge.
- R2: While `armed` is 0, a clock edge with `lamp_red` at 0 and `rst` at 0 leaves `armed` at 0. This holds for green, for both lamps off, and for any other non-red light.
- R3: While `armed` is 0, a clock edge with `lamp_red` at 1 and `rst` at 0 sets `armed` to 1 for the following cycle.
- R4: While `armed` is 1, every clock edge with `rst` at 0 keeps `armed` at 1, whatever the lamp inputs are.
- R5: `go_flag` equals `armed` AND `lamp_green` within the same cycle, with no register between them. While `armed` is 1, `go_flag` is 1 exactly when `lamp_green` is 1, even if `lamp_red` is also 1.
- R6: While `armed` is 0, `go_flag` is 0 even when `lamp_green` is 1.
- R7: `lamp_red` and `lamp_green` are not expected to be 1 together. If both are 1 at a clock edge while `armed` is 0, red decides the transition: `armed` becomes 1, and `go_flag` stays 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lamp_red | input | 1 | 1 when the light shows red |
| lamp_green | input | 1 | 1 when the light shows green |
| go_flag | output | 1 | Detect output: a red was seen earlier and the light is green now |
| armed | output | 1 | History bit: 1 once a red has been sampled since reset |

## Verification
The bench applies green light to a freshly reset detector. A design that only looked at the present colour would raise `go_flag` there. It then sends a single red followed by green. This exposes a detector that registers its output, because `go_flag` would come one cycle late, and a detector that forgets the red after a non-green cycle, because `armed` would fall back. It also drives both lamps together, in the idle state and in the armed state, so that a green-priority decode or an output gated by red shows up as a wrong `armed` or `go_flag`. Finally it resets the detector while red is still on, which catches a reset that loses priority to the red-triggered set.

// File: rtl/light_watch_pkg.sv
package light_watch_pkg;

    typedef enum logic {
        ST_NO_RED  = 1'b0,
        ST_RED_SEEN = 1'b1
    } watch_state_e;

    typedef struct packed {
        watch_state_e st;
    } watch_regs_t;

    typedef struct packed {
        logic arm_req;
        logic go_req;
    } lamp_req_t;

endpackage

// File: rtl/lamp_decode.sv
module lamp_decode
    import light_watch_pkg::*;
(
    input  logic      red_i,
    input  logic      green_i,
    output lamp_req_t req_o
);

    // Red alone decides the history transition; green alone feeds the output.
    always_comb begin
        req_o.arm_req = red_i;
        req_o.go_req  = green_i;
    end

endmodule

// File: rtl/watch_fsm.sv
module watch_fsm
    import light_watch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_req,
    output watch_state_e state_o
);

    watch_regs_t regs_d;
    watch_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.st = ST_NO_RED;
        end else begin
            unique case (regs_q.st)
                ST_NO_RED:   if (arm_req) regs_d.st = ST_RED_SEEN;
                ST_RED_SEEN: regs_d.st = ST_RED_SEEN;
                default:     regs_d.st = ST_NO_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.st;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (state_o == ST_NO_RED)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_NO_RED && !arm_req) |=> (state_o == ST_NO_RED)); // R2
    AST_RED_ARMS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_NO_RED && arm_req) |=> (state_o == ST_RED_SEEN)); // R3
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RED_SEEN) |=> (state_o == ST_RED_SEEN)); // R4

endmodule

// File: rtl/go_output.sv
module go_output
    import light_watch_pkg::*;
(
    input  watch_state_e state_i,
    input  logic         go_req,
    output logic         go_o
);

    always_comb begin
        go_o = (state_i == ST_RED_SEEN) && go_req;
    end

endmodule

// File: rtl/seen_red_go_detector.sv
module seen_red_go_detector
    import light_watch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lamp_red,
    input  logic lamp_green,
    output logic go_flag,
    output logic armed
);

    lamp_req_t    req;
    watch_state_e state;

    lamp_decode u_decode (
        .red_i   (lamp_red),
        .green_i (lamp_green),
        .req_o   (req)
    );

    watch_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .arm_req (req.arm_req),
        .state_o (state)
    );

    go_output u_out (
        .state_i (state),
        .go_req  (req.go_req),
        .go_o    (go_flag)
    );

    assign armed = (state == ST_RED_SEEN);

    AST_GO_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        go_flag |-> (armed && lamp_green)); // R6
    AST_GO_ON_GREEN: assert property (@(posedge clk) disable iff (rst)
        (armed && lamp_green) |-> go_flag); // R5
    AST_BOTH_LAMPS_ARM: assert property (@(posedge clk) disable iff (rst)
        (!armed && lamp_red && lamp_green) |=> armed); // R7

endmodule

// File: tb/seen_red_go_detector_test.sv
module seen_red_go_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lamp_red = 1'b0;
    logic lamp_green = 1'b0;
    logic go_flag;
    logic armed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  go_exp;
        logic  armed_exp;
        string req;
    } expect_t;

    expect_t sb_q[$];
    logic model_armed = 1'b0;

    always #5 clk = ~clk;

    seen_red_go_detector uut (
        .clk        (clk),
        .rst        (rst),
        .lamp_red   (lamp_red),
        .lamp_green (lamp_green),
        .go_flag    (go_flag),
        .armed      (armed)
    );

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: at a falling edge, drive one cycle of inputs, queue the
    // expected outputs for that cycle, then advance the reference model.
    task automatic drive(input logic r, input logic red, input logic green, input string req);
        expect_t e;
        @(negedge clk);
        rst = r;
        lamp_red = red;
        lamp_green = green;
        e.go_exp = model_armed & green;
        e.armed_exp = model_armed;
        e.req = req;
        sb_q.push_back(e);
        if (r) model_armed = 1'b0;
        else if (red) model_armed = 1'b1;
    endtask

    // Monitor: a little after the inputs settle, compare against the queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                expect_t e;
                e = sb_q.pop_front();
                checks++;
                if (go_flag !== e.go_exp || armed !== e.armed_exp) begin
                    errors++;
                    $display("FAIL %s: go_flag=%b armed=%b expected go_flag=%b armed=%b",
                             e.req, go_flag, armed, e.go_exp, e.armed_exp);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: cycles=%0d expected under 5000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        // Initial reset edge with no comparison: state is unknown before it.
        @(negedge clk);
        rst = 1'b1;
        model_armed = 1'b0;
        // R1: reset state is observed; reset held with red on still clears.
        drive(1'b1, 1'b1, 1'b0, "R1 reset with red");
        drive(1'b0, 1'b0, 1'b1, "R1 armed low after reset");
        // R6 / R2: green without a prior red.
        drive(1'b0, 1'b0, 1'b1, "R6 green unarmed");
        drive(1'b0, 1'b0, 1'b0, "R2 dark unarmed");
        drive(1'b0, 1'b0, 1'b1, "R2 still unarmed");
        // R3: red arms, R5: green then detects in the same cycle.
        drive(1'b0, 1'b1, 1'b0, "R3 red seen");
        drive(1'b0, 1'b0, 1'b1, "R5 green after red");
        drive(1'b0, 1'b0, 1'b0, "R5 dark while armed");
        drive(1'b0, 1'b0, 1'b1, "R4 armed kept, green");
        drive(1'b0, 1'b1, 1'b0, "R4 red while armed");
        drive(1'b0, 1'b1, 1'b1, "R5 both lamps armed");
        drive(1'b0, 1'b0, 1'b0, "R4 sticky");
        // R1: reset while armed and red on.
        drive(1'b1, 1'b1, 1'b1, "R1 reset while armed");
        drive(1'b0, 1'b0, 1'b1, "R1 cleared by reset");
        // R7: both lamps in idle state, red wins.
        drive(1'b0, 1'b1, 1'b1, "R7 both lamps idle");
        drive(1'b0, 1'b0, 1'b1, "R7 armed after both");
        drive(1'b0, 1'b0, 1'b0, "R7 armed hold");
        // Longer mixed pattern after another reset.
        drive(1'b1, 1'b0, 1'b0, "R1 reset again");
        for (int i = 0; i < 12; i++) begin
            drive(1'b0, (i == 7), (i % 3 == 0), "R2 R3 R5 mixed pattern");
        end
        @(negedge clk);
        @(negedge clk);
        #4;
        done = 1'b1;
        finish_run();
    end

endmodule